// File: doc/BRIEF.md
# Keyed-Start Watchdog Timer

This peripheral is a watchdog counter behind a small 32-bit register port. Once running, the counter climbs from a programmed load value. When it wraps past all-ones, the block raises a reset request for a fixed number of clock cycles and starts over from the load value. Software keeps the system alive by writing the trigger register, which restarts the count from the load value. A prescaler can slow the count by a power of two.

Counting can only be switched on or off by writing two key words, in order, to the key register. Each write to a control-type register is posted. The value is held in a shadow stage for a fixed settling delay before it takes effect, and a status word shows which writes are still in flight. While a write to a register is in flight, further writes to that same register are dropped. Software therefore polls the status word before writing again. It reads the live counter to work out the time remaining before the reset request.

Top module: `wdk_top`

## Requirements
- R1: After reset the counter is running, the prescaler is off (control reads 0), the load register reads 0xFFFF8000, the pending status reads 0, and the counter starts from 0xFFFF8000.
- R2: Writing 0x0000BBBB and then 0x00004444 to the key register (word address 5) makes the counter run. It then rises by one per cycle while the prescaler is off.
- R3: Writing 0x0000AAAA and then 0x00005555 to the key register stops the counter. While stopped, its value holds.
- R4: A first key word followed by any word that is not its matching second word leaves the run state unchanged and drops the sequence. A matching second word arriving alone has no effect.
- R5: The pending status word (address 6) has one bit for each posted register: bit 0 control, bit 2 load, bit 3 trigger, bit 4 key. An accepted write holds its bit set for exactly SYNC_DLY cycles, and the value takes effect as the bit clears.
- R6: A write to a register whose pending bit is set is ignored.
- R7: When a trigger write (address 4) takes effect with a value that differs from the trigger register's current contents, the counter is reloaded from the load register (address 3). The prescaler phase restarts at the same time.
- R8: A trigger write whose value equals the current trigger contents does not reload the counter.
- R9: In the control register (address 1), bit 5 enables the prescaler and bits 4:2 hold an exponent k. With the prescaler enabled the counter advances once every 2^k cycles; with it disabled the counter advances every cycle, whatever k holds.
- R10: When the counter advances from 0xFFFFFFFF, it is reloaded from the load register, and wdt_rst is raised for exactly RST_CYCLES (default 8) cycles, starting on that same edge.
- R11: Address 2 returns the live counter value, address 0 returns REV_CODE (default 0x3A) in bits 7:0, and control, load and trigger read back their applied values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_addr | input | 3 | Word address: 0 revision, 1 control, 2 counter, 3 load, 4 trigger, 5 key, 6 pending status |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| wdt_rst | output | 1 | Reset request pulse on counter overflow |

## Verification
The count rate is swept over every prescaler exponent with the enable bit set, and once with it clear but a nonzero exponent. Each window is a whole multiple of the largest division, so an off-by-one in the divide or a wrong exponent field shows up as an exact count mismatch. Key handling is tried with both correct pairs, a start word broken by a stray word, and a lone second word; these separate a proper two-step sequencer from one that reacts to single words. Trigger writes alternate between a changed value, a repeated value and an inverted value, which tells change-detection apart from reload-on-any-write. A load value just below all-ones is used to measure the pulse width and the overflow period exactly.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
  localparam int          ADDR_W  = 3;
  localparam int          DATA_W  = 32;
  localparam logic [2:0]  A_REV   = 3'd0;
  localparam logic [2:0]  A_CTRL  = 3'd1;
  localparam logic [2:0]  A_COUNT = 3'd2;
  localparam logic [2:0]  A_LOAD  = 3'd3;
  localparam logic [2:0]  A_TRIG  = 3'd4;
  localparam logic [2:0]  A_KEY   = 3'd5;
  localparam logic [2:0]  A_PEND  = 3'd6;

  localparam logic [31:0] KEY_RUN_A  = 32'h0000_BBBB;
  localparam logic [31:0] KEY_RUN_B  = 32'h0000_4444;
  localparam logic [31:0] KEY_HALT_A = 32'h0000_AAAA;
  localparam logic [31:0] KEY_HALT_B = 32'h0000_5555;

  typedef enum logic [1:0] {
    KS_IDLE,
    KS_RUN_ARMED,
    KS_HALT_ARMED
  } key_state_e;
endpackage

// File: rtl/wdk_post_slot.sv
// Posted-write stage: captures a write, holds it for DLY cycles, then
// presents it for one cycle as apply_o.
module wdk_post_slot #(
  parameter int W   = 32,
  parameter int DLY = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] data_i,
  output logic         pend_o,
  output logic         apply_o,
  output logic [W-1:0] data_o
);
  localparam int CW = $clog2(DLY + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [W-1:0]  shd_q, shd_d;
  logic          accept;

  assign accept = wr_i && (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    shd_d = shd_q;
    if (accept) begin
      cnt_d = CW'(DLY);
      shd_d = data_i;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      shd_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      shd_q <= shd_d;
    end
  end

  assign pend_o  = (cnt_q != '0);
  assign apply_o = (cnt_q == CW'(1));
  assign data_o  = shd_q;

  // R5
  accept_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !pend_o) |=> pend_o);
  // R6
  busy_write_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && pend_o) |=> $stable(data_o));
endmodule

// File: rtl/wdk_prescaler.sv
// Count-enable generator: one tick every 2^exp cycles when enabled.
module wdk_prescaler #(
  parameter int EXP_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [EXP_W-1:0] exp_i,
  input  logic             clr_i,
  output logic             tick_o
);
  localparam int PCW = (1 << EXP_W) - 1;

  logic [PCW-1:0] div_q, div_d;
  logic [PCW:0]   span;
  logic [PCW-1:0] limit;

  always_comb begin
    span        = '0;
    span[exp_i] = 1'b1;
    limit       = span[PCW-1:0] - PCW'(1);
  end

  assign tick_o = !en_i || (div_q == limit);

  always_comb begin
    if (clr_i || tick_o) div_d = '0;
    else                 div_d = div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  // R9
  div_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_i && $stable(exp_i) && !clr_i |=> (div_q <= limit));
endmodule

// File: rtl/wdk_keyseq.sv
// Two-word key sequencer controlling the run flag.
module wdk_keyseq
  import wdk_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          apply_i,
  input  logic [DW-1:0] word_i,
  output logic          run_o
);
  key_state_e st_q, st_d;
  logic       run_q, run_d;

  always_comb begin
    st_d  = st_q;
    run_d = run_q;
    if (apply_i) begin
      if      (word_i == DW'(KEY_RUN_A))  st_d = KS_RUN_ARMED;
      else if (word_i == DW'(KEY_HALT_A)) st_d = KS_HALT_ARMED;
      else                                st_d = KS_IDLE;
      if (st_q == KS_RUN_ARMED && word_i == DW'(KEY_RUN_B)) begin
        run_d = 1'b1;
        st_d  = KS_IDLE;
      end
      if (st_q == KS_HALT_ARMED && word_i == DW'(KEY_HALT_B)) begin
        run_d = 1'b0;
        st_d  = KS_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= KS_IDLE;
      run_q <= 1'b1;
    end else begin
      st_q  <= st_d;
      run_q <= run_d;
    end
  end

  assign run_o = run_q;

  // R2
  start_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (apply_i && st_q == KS_RUN_ARMED && word_i == DW'(KEY_RUN_B)) |=> run_o);
  // R3
  stop_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (apply_i && st_q == KS_HALT_ARMED && word_i == DW'(KEY_HALT_B)) |=> !run_o);
  // R4
  no_apply_keeps_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !apply_i |=> $stable(run_o));
endmodule

// File: rtl/wdk_counter.sv
// Up-counter with reload, overflow detection and reset pulse stretcher.
module wdk_counter #(
  parameter int CW   = 32,
  parameter int RSTC = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          run_i,
  input  logic          reload_i,
  input  logic [CW-1:0] load_i,
  input  logic [CW-1:0] init_i,
  output logic [CW-1:0] cnt_o,
  output logic          rst_o
);
  localparam int PW = $clog2(RSTC + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [PW-1:0] pul_q, pul_d;
  logic          wrap;

  assign wrap = run_i && tick_i && (cnt_q == '1) && !reload_i;

  always_comb begin
    cnt_d = cnt_q;
    if (reload_i || wrap)      cnt_d = load_i;
    else if (run_i && tick_i)  cnt_d = cnt_q + 1'b1;
  end

  always_comb begin
    if (wrap)              pul_d = PW'(RSTC);
    else if (pul_q != '0)  pul_d = pul_q - 1'b1;
    else                   pul_d = pul_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= init_i;
      pul_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      pul_q <= pul_d;
    end
  end

  assign cnt_o = cnt_q;
  assign rst_o = (pul_q != '0);

  // R10
  pulse_after_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_o) |-> ($past(cnt_q) == '1));
  // R3
  halted_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !reload_i) |=> $stable(cnt_q));
  // R7
  reload_takes_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reload_i |=> (cnt_q == $past(load_i)));
endmodule

// File: rtl/wdk_top.sv
module wdk_top
  import wdk_pkg::*;
#(
  parameter int          SYNC_DLY  = 4,
  parameter int          RST_CYCLES = 8,
  parameter int          EXP_W     = 3,
  parameter logic [7:0]  REV_CODE  = 8'h3A,
  parameter logic [31:0] LOAD_INIT = 32'hFFFF_8000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        wdt_rst
);
  localparam int CTRL_W = EXP_W + 3;
  localparam int EN_BIT = EXP_W + 2;

  // reset: asynchronous assert, synchronous release
  logic rsync_q1, rsync_q2, rn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q1 <= 1'b0;
      rsync_q2 <= 1'b0;
    end else begin
      rsync_q1 <= 1'b1;
      rsync_q2 <= rsync_q1;
    end
  end
  assign rn = rsync_q2;

  logic wr_ctrl, wr_load, wr_trig, wr_key;
  assign wr_ctrl = reg_we && (reg_addr == A_CTRL);
  assign wr_load = reg_we && (reg_addr == A_LOAD);
  assign wr_trig = reg_we && (reg_addr == A_TRIG);
  assign wr_key  = reg_we && (reg_addr == A_KEY);

  logic              p_ctrl, p_load, p_trig, p_key;
  logic              a_ctrl, a_load, a_trig, a_key;
  logic [CTRL_W-1:0] s_ctrl;
  logic [31:0]       s_load, s_trig, s_key;

  wdk_post_slot #(.W(CTRL_W), .DLY(SYNC_DLY)) u_ps_ctrl (
    .clk(clk), .rst_n(rn), .wr_i(wr_ctrl), .data_i(reg_wdata[CTRL_W-1:0]),
    .pend_o(p_ctrl), .apply_o(a_ctrl), .data_o(s_ctrl));
  wdk_post_slot #(.W(32), .DLY(SYNC_DLY)) u_ps_load (
    .clk(clk), .rst_n(rn), .wr_i(wr_load), .data_i(reg_wdata),
    .pend_o(p_load), .apply_o(a_load), .data_o(s_load));
  wdk_post_slot #(.W(32), .DLY(SYNC_DLY)) u_ps_trig (
    .clk(clk), .rst_n(rn), .wr_i(wr_trig), .data_i(reg_wdata),
    .pend_o(p_trig), .apply_o(a_trig), .data_o(s_trig));
  wdk_post_slot #(.W(32), .DLY(SYNC_DLY)) u_ps_key (
    .clk(clk), .rst_n(rn), .wr_i(wr_key), .data_i(reg_wdata),
    .pend_o(p_key), .apply_o(a_key), .data_o(s_key));

  // applied registers
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [31:0]       load_q, load_d, trig_q, trig_d;
  logic              reload;

  assign reload = a_trig && (s_trig != trig_q);

  always_comb begin
    ctrl_d = a_ctrl ? s_ctrl : ctrl_q;
    load_d = a_load ? s_load : load_q;
    trig_d = a_trig ? s_trig : trig_q;
  end

  always_ff @(posedge clk or negedge rn) begin
    if (!rn) begin
      ctrl_q <= '0;
      load_q <= LOAD_INIT;
      trig_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      load_q <= load_d;
      trig_q <= trig_d;
    end
  end

  logic run, tick;
  logic [31:0] cnt;

  wdk_keyseq #(.DW(32)) u_keys (
    .clk(clk), .rst_n(rn), .apply_i(a_key), .word_i(s_key), .run_o(run));

  wdk_prescaler #(.EXP_W(EXP_W)) u_psc (
    .clk(clk), .rst_n(rn), .en_i(ctrl_q[EN_BIT]), .exp_i(ctrl_q[EN_BIT-1:2]),
    .clr_i(reload), .tick_o(tick));

  wdk_counter #(.CW(32), .RSTC(RST_CYCLES)) u_cnt (
    .clk(clk), .rst_n(rn), .tick_i(tick), .run_i(run), .reload_i(reload),
    .load_i(load_q), .init_i(LOAD_INIT), .cnt_o(cnt), .rst_o(wdt_rst));

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_REV:   reg_rdata = {24'h0, REV_CODE};
      A_CTRL:  reg_rdata = 32'(ctrl_q);
      A_COUNT: reg_rdata = cnt;
      A_LOAD:  reg_rdata = load_q;
      A_TRIG:  reg_rdata = trig_q;
      A_PEND:  reg_rdata = {27'h0, p_key, p_trig, p_load, 1'b0, p_ctrl};
      default: reg_rdata = '0;
    endcase
  end

  // R8
  same_trigger_no_reload_chk: assert property (@(posedge clk) disable iff (!rn)
    (a_trig && s_trig == trig_q) |-> !reload);
  // R5
  pend_only_from_write_chk: assert property (@(posedge clk) disable iff (!rn)
    (!wr_load && !p_load) |=> !p_load);
endmodule

// File: tb/wdk_top_tb.sv
module wdk_top_tb;
  localparam int SYNC = 4;
  localparam int RSTC = 8;

  logic        clk, rst_n, reg_we;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        wdt_rst;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  wdk_top u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wdt_rst(wdt_rst));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] p;
    for (int i = 0; i < 100; i++) begin
      rd(3'd6, p);
      if (p == 32'h0) break;
      step(1);
    end
  endtask

  task automatic raw_wr(input logic [2:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    step(1);
    reg_we = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wait_idle();
    raw_wr(a, d);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, c1, c2;
    int n, m;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    step(3);
    rst_n = 1'b1;
    step(3);

    // R1 reset state, R11 revision
    rd(3'd6, v); check("R1 pend", v, 32'h0);
    rd(3'd1, v); check("R1 ctrl", v, 32'h0);
    rd(3'd3, v); check("R1 load", v, 32'hFFFF8000);
    rd(3'd0, v); check("R11 rev", {24'h0, v[7:0]}, 32'h3A);
    rd(3'd2, c1);
    check("R1 count near init", {31'h0, (c1 >= 32'hFFFF8000 && c1 < 32'hFFFF8010)}, 32'h1);
    step(10); rd(3'd2, c2); check("R1 running", c2 - c1, 32'd10);

    // R3 stop
    wr(3'd5, 32'h0000AAAA); wr(3'd5, 32'h00005555); wait_idle();
    rd(3'd2, c1); step(50); rd(3'd2, c2); check("R3 halted", c2, c1);

    // R4 broken sequence and lone second word
    wr(3'd5, 32'h0000BBBB); wr(3'd5, 32'h00001234); wr(3'd5, 32'h00004444); wait_idle();
    rd(3'd2, c1); step(20); rd(3'd2, c2); check("R4 cancel", c2, c1);
    wr(3'd5, 32'h00004444); wait_idle();
    rd(3'd2, c1); step(20); rd(3'd2, c2); check("R4 lone second", c2, c1);

    // R2 start, R11 counter readback
    wr(3'd5, 32'h0000BBBB); wr(3'd5, 32'h00004444); wait_idle();
    rd(3'd2, c1); step(40); rd(3'd2, c2); check("R2 running R11", c2 - c1, 32'd40);

    // R5 pending bit position and duration
    wr(3'd3, 32'h00000100);
    rd(3'd6, v); check("R5 load bit", v, 32'h04);
    n = 0;
    for (int i = 0; i < 20; i++) begin
      rd(3'd6, v);
      if (v == 32'h0) break;
      n++; step(1);
    end
    check("R5 duration", n, SYNC);
    wr(3'd4, 32'h00000077); rd(3'd6, v); check("R5 trig bit", v, 32'h08);
    wait_idle();
    wr(3'd5, 32'h00000000); rd(3'd6, v); check("R5 key bit", v, 32'h10);
    wait_idle();
    wr(3'd1, 32'h00000000); rd(3'd6, v); check("R5 ctrl bit", v, 32'h01);
    wait_idle();

    // R6 write during pending dropped
    wr(3'd3, 32'h00000200); raw_wr(3'd3, 32'h00000300); wait_idle();
    rd(3'd3, v); check("R6 load kept", v, 32'h00000200);
    wr(3'd3, 32'h00000100); wait_idle();

    // R7 reload on changed trigger
    wr(3'd4, 32'h00001234); wait_idle();
    rd(3'd2, v); check("R7 reload", v, 32'h00000100);
    rd(3'd4, v); check("R11 trig readback", v, 32'h00001234);
    // R8 same value: no reload
    wr(3'd4, 32'h00001234); wait_idle();
    rd(3'd2, v); check("R8 no reload", v, 32'h00000105);
    wr(3'd4, ~32'h00001234); wait_idle();
    rd(3'd2, v); check("R7 inverted reload", v, 32'h00000100);

    // R9 prescaler sweep
    wr(3'd3, 32'h0); wait_idle();
    for (int k = 0; k < 8; k++) begin
      wr(3'd1, 32'h20 | (k << 2)); wait_idle();
      rd(3'd1, v); check("R9 ctrl readback", v, 32'h20 | (k << 2));
      wr(3'd4, 32'h50 + k); wait_idle();
      rd(3'd2, c1); step(256); rd(3'd2, c2);
      check($sformatf("R9 div exp %0d", k), c2 - c1, 32'd256 >> k);
    end
    wr(3'd1, 32'h0C); wait_idle();
    rd(3'd2, c1); step(256); rd(3'd2, c2); check("R9 disabled", c2 - c1, 32'd256);

    // R10 overflow pulse and period
    wr(3'd1, 32'h0); wr(3'd3, 32'hFFFFFFF0); wr(3'd4, 32'h99); wait_idle();
    for (int i = 0; i < 100; i++) begin
      if (wdt_rst) break;
      step(1);
    end
    check("R10 pulse seen", {31'h0, wdt_rst}, 32'h1);
    rd(3'd2, v); check("R10 reload", v, 32'hFFFFFFF0);
    n = 0;
    for (int i = 0; i < 100; i++) begin
      if (!wdt_rst) break;
      n++; step(1);
    end
    check("R10 width", n, RSTC);
    m = 0;
    for (int i = 0; i < 100; i++) begin
      if (wdt_rst) break;
      m++; step(1);
    end
    check("R10 period", n + m, 32'd16);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule